// File: doc/BRIEF.md
# Per-Instruction Memory Request Coalescer

This block sits between the lanes of a vector execution unit and the first-level data cache. Each lane's memory request arrives as a packet carrying the sequence number of the instruction that issued it. The packet also carries its lane index, the cache-line address it touches, a request kind and the total number of packets the instruction will send. Packets are parked in a staging table that has one column per instruction in flight. Once every packet of the oldest instruction has arrived, a controller walks that column. It folds packets that share a line into a single coalesced request with a lane mask, and places each coalesced request in a small miss-holding table. It then sends the requests of that instruction downstream one per cycle.

A response names a line address. It releases the oldest issued entry for that line and reports, in the same cycle, the merged lanes and the instruction they belong to. The number of live entries is capped by a parameter. When the cap is reached, merging pauses until a response frees an entry. A sticky error flag is raised when an instruction has occupied a staging column for too long.

The controller is a four-state machine. ST_IDLE waits for the oldest column to be complete and moves to ST_MERGE. ST_MERGE handles one staged packet per cycle. It stays in place while no entry can be allocated, and moves to ST_ISSUE after the last packet. ST_ISSUE sends one unsent request of the current instruction per cycle and moves to ST_FREE when none remain. ST_FREE releases the column and returns to ST_IDLE.

Top module: `mem_coalescer`

## Requirements
- R1: Staging columns are drained strictly oldest sequence number first. A column is drained only once it holds as many packets as its instruction announced, so a younger complete instruction waits behind an older incomplete one.
- R2: An instruction's packet count is taken from its first accepted packet only. The count carried by later packets of the same sequence number is ignored.
- R3: Packets of the same instruction that target the same line become one request. Its lane mask has bit i set for each merged lane i, and its kind comes from the first such packet. Packets of different instructions never merge, even when their lines are equal.
- R4: A new table entry is allocated only while fewer than MAX_OUT entries are live. Otherwise merging pauses and nothing is issued until a response frees an entry.
- R5: After an instruction is fully merged, its requests are issued one per cycle on iss_valid with iss_line, iss_type and iss_mask. They go out in ascending table-slot order, and allocation always takes the lowest free slot. Kind encoding: 0 load, 1 store, 2 atomic.
- R6: A response releases the issued entry for rsp_line with the earliest issue cycle. In the same cycle cpl_valid rises, with cpl_mask equal to that entry's lane mask and cpl_seq equal to its sequence number. A response whose line matches no issued entry produces no completion.
- R7: in_stall is high exactly when all COLS staging columns are occupied and in_seq matches none of them. Otherwise a packet with in_valid is accepted. The staging table holds COLS times LANES packets.
- R8: dl_err rises once a staging column has stayed occupied for DL_THRESH cycles. It then stays high until reset.
- R9: After reset, in_stall, iss_valid, cpl_valid and dl_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane packet present |
| in_seq | input | SEQ_W | Instruction sequence number |
| in_lane | input | log2(LANES) | Issuing lane |
| in_line | input | LINE_W | Cache-line address |
| in_type | input | 2 | Request kind (0 load, 1 store, 2 atomic) |
| in_count | input | log2(LANES+1) | Packets the instruction will send |
| in_stall | output | 1 | Packet cannot be accepted this cycle |
| iss_valid | output | 1 | Coalesced request issued |
| iss_tag | output | log2(MAX_OUT) | Table slot of the issued request |
| iss_line | output | LINE_W | Line of the issued request |
| iss_type | output | 2 | Kind of the issued request |
| iss_mask | output | LANES | Merged lanes of the issued request |
| rsp_valid | input | 1 | Response returned |
| rsp_line | input | LINE_W | Line of the response |
| cpl_valid | output | 1 | Lane completions reported |
| cpl_mask | output | LANES | Lanes completed |
| cpl_seq | output | SEQ_W | Instruction of the completed lanes |
| dl_err | output | 1 | Sticky staging-timeout flag |

## Verification
The bench builds the block with four lanes, two staging columns, MAX_OUT of 2 and DL_THRESH of 60. With only two columns, two partly sent instructions fill the table, which exercises both the stall and the case where a younger instruction completes first. With only two entries, two unanswered requests are enough to block a third instruction's merge until a response arrives. The short threshold lets a deliberately incomplete instruction trip the timeout flag within the run, while ordinary traffic stays well below it.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        KIND_LOAD   = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_ATOMIC = 2'd2,
        KIND_RSVD   = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MERGE,
        ST_ISSUE,
        ST_FREE
    } ctl_state_t;
endpackage

// File: rtl/coal_stage.sv
module coal_stage
    import coal_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int COLS      = 2,
    parameter int SEQ_W     = 8,
    parameter int LINE_W    = 12,
    parameter int DL_THRESH = 1000,
    localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W    = $clog2(LANES + 1),
    localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [LANE_W-1:0] in_lane,
    input  logic [LINE_W-1:0] in_line,
    input  logic [1:0]        in_type,
    input  logic [CNT_W-1:0]  in_count,
    output logic              in_stall,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [LANE_W-1:0] rd_idx,
    output logic [LANE_W-1:0] rd_lane,
    output logic [LINE_W-1:0] rd_line,
    output req_kind_t         rd_type,
    output logic              head_ok,
    output logic [COL_W-1:0]  head_col,
    output logic [SEQ_W-1:0]  head_seq,
    output logic [CNT_W-1:0]  head_cnt,
    input  logic              free_en,
    input  logic [COL_W-1:0]  free_col,
    output logic              dl_err
);
    localparam int DL_W = $clog2(DL_THRESH + 1);

    logic [COLS-1:0]    c_vld;
    logic [SEQ_W-1:0]   c_seq  [COLS];
    logic [CNT_W-1:0]   c_cnt  [COLS];
    logic [CNT_W-1:0]   c_rcv  [COLS];
    logic [DL_W-1:0]    c_wait [COLS];
    logic [LANE_W-1:0]  s_lane [COLS][LANES];
    logic [LINE_W-1:0]  s_line [COLS][LANES];
    req_kind_t          s_type [COLS][LANES];

    logic             m_hit, f_hit, accept, full, any_late;
    logic [COL_W-1:0] m_idx, f_idx, w_col;

    always_comb begin
        m_hit = 1'b0;
        m_idx = '0;
        f_hit = 1'b0;
        f_idx = '0;
        for (int i = 0; i < COLS; i++) begin
            if (c_vld[i] && c_seq[i] == in_seq && !m_hit) begin
                m_hit = 1'b1;
                m_idx = COL_W'(i);
            end
            if (!c_vld[i] && !f_hit) begin
                f_hit = 1'b1;
                f_idx = COL_W'(i);
            end
        end
    end

    assign full     = &c_vld;
    assign in_stall = full && !m_hit;
    assign accept   = in_valid && !in_stall;
    assign w_col    = m_hit ? m_idx : f_idx;

    always_comb begin
        logic hfound;
        hfound   = 1'b0;
        head_col = '0;
        head_seq = '0;
        for (int i = 0; i < COLS; i++) begin
            if (c_vld[i] && (!hfound || c_seq[i] < head_seq)) begin
                hfound   = 1'b1;
                head_col = COL_W'(i);
                head_seq = c_seq[i];
            end
        end
        head_cnt = c_cnt[head_col];
        head_ok  = hfound && (c_rcv[head_col] == c_cnt[head_col]);
    end

    assign rd_lane = s_lane[rd_col][rd_idx];
    assign rd_line = s_line[rd_col][rd_idx];
    assign rd_type = s_type[rd_col][rd_idx];

    always_comb begin
        any_late = 1'b0;
        for (int i = 0; i < COLS; i++) begin
            if (c_vld[i] && c_wait[i] == DL_W'(DL_THRESH)) any_late = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_vld  <= '0;
            dl_err <= 1'b0;
            for (int i = 0; i < COLS; i++) begin
                c_seq[i]  <= '0;
                c_cnt[i]  <= '0;
                c_rcv[i]  <= '0;
                c_wait[i] <= '0;
            end
        end else begin
            dl_err <= dl_err | any_late;
            for (int i = 0; i < COLS; i++) begin
                if (c_vld[i] && c_wait[i] != DL_W'(DL_THRESH)) c_wait[i] <= c_wait[i] + 1'b1;
            end
            if (free_en) c_vld[free_col] <= 1'b0;
            if (accept) begin
                if (m_hit) begin
                    c_rcv[w_col] <= c_rcv[w_col] + 1'b1;
                end else begin
                    c_vld[w_col]  <= 1'b1;
                    c_seq[w_col]  <= in_seq;
                    c_cnt[w_col]  <= in_count;
                    c_rcv[w_col]  <= CNT_W'(1);
                    c_wait[w_col] <= '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            s_lane[w_col][m_hit ? LANE_W'(c_rcv[w_col]) : '0] <= in_lane;
            s_line[w_col][m_hit ? LANE_W'(c_rcv[w_col]) : '0] <= in_line;
            s_type[w_col][m_hit ? LANE_W'(c_rcv[w_col]) : '0] <= req_kind_t'(in_type);
        end
    end

    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |-> (&c_vld)); // R7
    AST_DL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dl_err |=> dl_err); // R8
endmodule

// File: rtl/coal_mshr.sv
module coal_mshr
    import coal_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int MAX_OUT = 4,
    parameter int SEQ_W   = 8,
    parameter int LINE_W  = 12,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int TAG_W  = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
    localparam int OC_W   = $clog2(MAX_OUT + 1),
    localparam int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEQ_W-1:0]  lk_seq,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [LANE_W-1:0] lk_lane,
    input  req_kind_t         lk_type,
    output logic              lk_hit,
    output logic              has_free,
    input  logic              merge_en,
    input  logic              alloc_en,
    output logic              iq_found,
    output logic [TAG_W-1:0]  iq_idx,
    output logic [LINE_W-1:0] iq_line,
    output req_kind_t         iq_type,
    output logic [LANES-1:0]  iq_mask,
    input  logic              iss_en,
    input  logic              rsp_valid,
    input  logic [LINE_W-1:0] rsp_line,
    output logic              cpl_valid,
    output logic [LANES-1:0]  cpl_mask,
    output logic [SEQ_W-1:0]  cpl_seq
);
    logic [MAX_OUT-1:0] m_vld, m_iss;
    logic [SEQ_W-1:0]   m_seq  [MAX_OUT];
    logic [LINE_W-1:0]  m_line [MAX_OUT];
    req_kind_t          m_type [MAX_OUT];
    logic [LANES-1:0]   m_mask [MAX_OUT];
    logic [TIME_W-1:0]  m_t    [MAX_OUT];
    logic [TIME_W-1:0]  now_t;
    logic [OC_W-1:0]    out_cnt;

    logic [TAG_W-1:0]   lk_idx, fr_idx, rs_idx;
    logic               fr_any, rs_hit;

    always_comb begin
        lk_hit   = 1'b0;
        lk_idx   = '0;
        fr_any   = 1'b0;
        fr_idx   = '0;
        iq_found = 1'b0;
        iq_idx   = '0;
        for (int i = 0; i < MAX_OUT; i++) begin
            if (m_vld[i] && !m_iss[i] && m_seq[i] == lk_seq && m_line[i] == lk_line && !lk_hit) begin
                lk_hit = 1'b1;
                lk_idx = TAG_W'(i);
            end
            if (!m_vld[i] && !fr_any) begin
                fr_any = 1'b1;
                fr_idx = TAG_W'(i);
            end
            if (m_vld[i] && !m_iss[i] && m_seq[i] == lk_seq && !iq_found) begin
                iq_found = 1'b1;
                iq_idx   = TAG_W'(i);
            end
        end
    end

    assign has_free = fr_any && (out_cnt < OC_W'(MAX_OUT));
    assign iq_line  = m_line[iq_idx];
    assign iq_type  = m_type[iq_idx];
    assign iq_mask  = m_mask[iq_idx];

    always_comb begin
        logic [TIME_W-1:0] best_age, age;
        rs_hit   = 1'b0;
        rs_idx   = '0;
        best_age = '0;
        for (int i = 0; i < MAX_OUT; i++) begin
            age = now_t - m_t[i];
            if (m_vld[i] && m_iss[i] && m_line[i] == rsp_line && (!rs_hit || age > best_age)) begin
                rs_hit   = 1'b1;
                rs_idx   = TAG_W'(i);
                best_age = age;
            end
        end
    end

    assign cpl_valid = rsp_valid && rs_hit;
    assign cpl_mask  = m_mask[rs_idx];
    assign cpl_seq   = m_seq[rs_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_vld   <= '0;
            m_iss   <= '0;
            now_t   <= '0;
            out_cnt <= '0;
        end else begin
            now_t   <= now_t + 1'b1;
            out_cnt <= out_cnt + OC_W'(alloc_en && has_free) - OC_W'(cpl_valid);
            if (cpl_valid) m_vld[rs_idx] <= 1'b0;
            if (iss_en && iq_found) begin
                m_iss[iq_idx] <= 1'b1;
                m_t[iq_idx]   <= now_t;
            end
            if (merge_en && lk_hit) m_mask[lk_idx][lk_lane] <= 1'b1;
            if (alloc_en && has_free) begin
                m_vld[fr_idx]  <= 1'b1;
                m_iss[fr_idx]  <= 1'b0;
                m_seq[fr_idx]  <= lk_seq;
                m_line[fr_idx] <= lk_line;
                m_type[fr_idx] <= lk_type;
                m_mask[fr_idx] <= LANES'(1) << lk_lane;
            end
        end
    end

    AST_ALLOC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (out_cnt < OC_W'(MAX_OUT))); // R4
    AST_CNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt == OC_W'($countones(m_vld))); // R4
    AST_MERGE_SETS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |=> m_mask[$past(lk_idx)][$past(lk_lane)]); // R3
    AST_CPL_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> rsp_valid); // R6
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int COLS      = 2,
    parameter int SEQ_W     = 8,
    parameter int LINE_W    = 12,
    parameter int MAX_OUT   = 4,
    parameter int DL_THRESH = 1000,
    localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W    = $clog2(LANES + 1),
    localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int TAG_W    = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [LANE_W-1:0] in_lane,
    input  logic [LINE_W-1:0] in_line,
    input  logic [1:0]        in_type,
    input  logic [CNT_W-1:0]  in_count,
    output logic              in_stall,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [LINE_W-1:0] iss_line,
    output logic [1:0]        iss_type,
    output logic [LANES-1:0]  iss_mask,
    input  logic              rsp_valid,
    input  logic [LINE_W-1:0] rsp_line,
    output logic              cpl_valid,
    output logic [LANES-1:0]  cpl_mask,
    output logic [SEQ_W-1:0]  cpl_seq,
    output logic              dl_err
);
    ctl_state_t        state, nxt;
    logic [COL_W-1:0]  cur_col;
    logic [SEQ_W-1:0]  cur_seq;
    logic [CNT_W-1:0]  cur_cnt;
    logic [LANE_W-1:0] ptr;

    logic              head_ok, free_en, merge_en, alloc_en, iss_en;
    logic [COL_W-1:0]  head_col;
    logic [SEQ_W-1:0]  head_seq;
    logic [CNT_W-1:0]  head_cnt;
    logic [LANE_W-1:0] rd_lane;
    logic [LINE_W-1:0] rd_line;
    req_kind_t         rd_type, iq_type;
    logic              lk_hit, has_free, iq_found, last_pkt, step;
    logic [TAG_W-1:0]  iq_idx;
    logic [LINE_W-1:0] iq_line;
    logic [LANES-1:0]  iq_mask;

    coal_stage #(
        .LANES(LANES), .COLS(COLS), .SEQ_W(SEQ_W), .LINE_W(LINE_W), .DL_THRESH(DL_THRESH)
    ) i_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_seq(in_seq), .in_lane(in_lane), .in_line(in_line),
        .in_type(in_type), .in_count(in_count), .in_stall(in_stall),
        .rd_col(cur_col), .rd_idx(ptr), .rd_lane(rd_lane), .rd_line(rd_line), .rd_type(rd_type),
        .head_ok(head_ok), .head_col(head_col), .head_seq(head_seq), .head_cnt(head_cnt),
        .free_en(free_en), .free_col(cur_col), .dl_err(dl_err)
    );

    coal_mshr #(
        .LANES(LANES), .MAX_OUT(MAX_OUT), .SEQ_W(SEQ_W), .LINE_W(LINE_W)
    ) i_mshr (
        .clk(clk), .rst_n(rst_n),
        .lk_seq(cur_seq), .lk_line(rd_line), .lk_lane(rd_lane), .lk_type(rd_type),
        .lk_hit(lk_hit), .has_free(has_free), .merge_en(merge_en), .alloc_en(alloc_en),
        .iq_found(iq_found), .iq_idx(iq_idx), .iq_line(iq_line), .iq_type(iq_type),
        .iq_mask(iq_mask), .iss_en(iss_en),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line),
        .cpl_valid(cpl_valid), .cpl_mask(cpl_mask), .cpl_seq(cpl_seq)
    );

    assign last_pkt = (CNT_W'(ptr) + CNT_W'(1)) == cur_cnt;
    assign step     = merge_en || alloc_en;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (head_ok) nxt = ST_MERGE;
            ST_MERGE: if (step && last_pkt) nxt = ST_ISSUE;
            ST_ISSUE: if (!iq_found) nxt = ST_FREE;
            ST_FREE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_col <= '0;
            cur_seq <= '0;
            cur_cnt <= '0;
            ptr     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && head_ok) begin
                cur_col <= head_col;
                cur_seq <= head_seq;
                cur_cnt <= head_cnt;
                ptr     <= '0;
            end else if (state == ST_MERGE && step && !last_pkt) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    always_comb begin
        merge_en = 1'b0;
        alloc_en = 1'b0;
        iss_en   = 1'b0;
        free_en  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_MERGE: begin
                if (lk_hit)        merge_en = 1'b1;
                else if (has_free) alloc_en = 1'b1;
            end
            ST_ISSUE: iss_en  = iq_found;
            ST_FREE:  free_en = 1'b1;
            default: ;
        endcase
    end

    assign iss_valid = iss_en;
    assign iss_tag   = iq_idx;
    assign iss_line  = iq_line;
    assign iss_type  = iq_type;
    assign iss_mask  = iq_mask;

    AST_MERGE_ON_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE) |-> (head_ok && head_col == cur_col)); // R1
    AST_ISSUE_AFTER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !$stable(state) || $past(state) == ST_ISSUE); // R5
endmodule

// File: tb/test_mem_coalescer.sv
module test_mem_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4, COLS = 2, SEQ_W = 8, LINE_W = 12, MAX_OUT = 2, DL_THRESH = 60;
    localparam int LANE_W = 2, CNT_W = 3, TAG_W = 1;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0;
    logic [SEQ_W-1:0] in_seq = 0;
    logic [LANE_W-1:0] in_lane = 0;
    logic [LINE_W-1:0] in_line = 0;
    logic [1:0] in_type = 0;
    logic [CNT_W-1:0] in_count = 0;
    logic in_stall, iss_valid, cpl_valid, dl_err;
    logic [TAG_W-1:0] iss_tag;
    logic [LINE_W-1:0] iss_line;
    logic [1:0] iss_type;
    logic [LANES-1:0] iss_mask, cpl_mask;
    logic [SEQ_W-1:0] cpl_seq;
    logic rsp_valid = 0;
    logic [LINE_W-1:0] rsp_line = 0;

    int n_chk = 0, n_fail = 0, iss_seen = 0, cpl_seen = 0;
    bit done = 0;
    logic [LINE_W+2+LANES-1:0] exp_iss[$];
    logic [SEQ_W+LANES-1:0]    exp_cpl[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_coalescer #(.LANES(LANES), .COLS(COLS), .SEQ_W(SEQ_W), .LINE_W(LINE_W),
                    .MAX_OUT(MAX_OUT), .DL_THRESH(DL_THRESH)) i_mem_coalescer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seq(in_seq), .in_lane(in_lane),
        .in_line(in_line), .in_type(in_type), .in_count(in_count), .in_stall(in_stall),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_line(iss_line), .iss_type(iss_type),
        .iss_mask(iss_mask), .rsp_valid(rsp_valid), .rsp_line(rsp_line),
        .cpl_valid(cpl_valid), .cpl_mask(cpl_mask), .cpl_seq(cpl_seq), .dl_err(dl_err));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (iss_valid) begin
                iss_seen++;
                if (exp_iss.size() == 0) chk(0, "R4/R5 unexpected issue", {iss_line, iss_type, iss_mask}, 0);
                else begin
                    logic [LINE_W+2+LANES-1:0] e;
                    e = exp_iss.pop_front();
                    chk({iss_line, iss_type, iss_mask} == e, "R3/R5 issued request", {iss_line, iss_type, iss_mask}, e);
                end
            end
            if (cpl_valid) begin
                cpl_seen++;
                if (exp_cpl.size() == 0) chk(0, "R6 unexpected completion", {cpl_seq, cpl_mask}, 0);
                else begin
                    logic [SEQ_W+LANES-1:0] e;
                    e = exp_cpl.pop_front();
                    chk({cpl_seq, cpl_mask} == e, "R6 completion", {cpl_seq, cpl_mask}, e);
                end
            end
        end
    end

    task automatic send(input int seq, input int lane, input int line, input int kind, input int cnt);
        in_valid = 1; in_seq = SEQ_W'(seq); in_lane = LANE_W'(lane);
        in_line = LINE_W'(line); in_type = 2'(kind); in_count = CNT_W'(cnt);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic respond(input int line);
        rsp_valid = 1; rsp_line = LINE_W'(line);
        @(posedge clk); #1;
        rsp_valid = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base, cbase;
        wait_cyc(3);
        @(negedge clk);
        chk(in_stall == 0, "R9 stall after reset", in_stall, 0);
        chk(iss_valid == 0, "R9 issue after reset", iss_valid, 0);
        chk(cpl_valid == 0, "R9 completion after reset", cpl_valid, 0);
        chk(dl_err == 0, "R9 dl_err after reset", dl_err, 0);
        @(posedge clk); #1;
        rst_n = 1;
        wait_cyc(2);

        // R3 R5: one instruction, two lines, merged lane masks
        exp_iss.push_back({12'h0A0, 2'd0, 4'b1011});
        exp_iss.push_back({12'h0B0, 2'd0, 4'b0100});
        base = iss_seen;
        send(1, 0, 'h0A0, 0, 4); send(1, 1, 'h0A0, 0, 4);
        send(1, 2, 'h0B0, 0, 4); send(1, 3, 'h0A0, 0, 4);
        wait_cyc(20);
        chk(iss_seen - base == 2, "R5 issue count", iss_seen - base, 2);
        exp_cpl.push_back({8'd1, 4'b1011}); respond('h0A0);
        exp_cpl.push_back({8'd1, 4'b0100}); respond('h0B0);
        wait_cyc(2);

        // R3 R6: same line, different instructions, oldest released first
        exp_iss.push_back({12'h0A0, 2'd1, 4'b0001});
        exp_iss.push_back({12'h0A0, 2'd1, 4'b0010});
        send(2, 0, 'h0A0, 1, 1);
        send(3, 1, 'h0A0, 1, 1);
        wait_cyc(20);
        exp_cpl.push_back({8'd2, 4'b0001}); respond('h0A0);
        exp_cpl.push_back({8'd3, 4'b0010}); respond('h0A0);
        cbase = cpl_seen;
        respond('h777);
        wait_cyc(2);
        chk(cpl_seen == cbase, "R6 unmatched response ignored", cpl_seen - cbase, 0);

        // R4: outstanding limit blocks a third request
        exp_iss.push_back({12'h0C0, 2'd2, 4'b0001});
        exp_iss.push_back({12'h0D0, 2'd0, 4'b0100});
        send(4, 0, 'h0C0, 2, 1);
        send(5, 2, 'h0D0, 0, 1);
        wait_cyc(20);
        base = iss_seen;
        send(6, 3, 'h0E0, 0, 1);
        wait_cyc(15);
        chk(iss_seen == base, "R4 no issue at limit", iss_seen - base, 0);
        exp_cpl.push_back({8'd4, 4'b0001});
        exp_iss.push_back({12'h0E0, 2'd0, 4'b1000});
        respond('h0C0);
        wait_cyc(10);
        chk(iss_seen - base == 1, "R4 issue after release", iss_seen - base, 1);
        exp_cpl.push_back({8'd5, 4'b0100}); respond('h0D0);
        exp_cpl.push_back({8'd6, 4'b1000}); respond('h0E0);
        wait_cyc(2);

        // R2: count of a later packet ignored
        exp_iss.push_back({12'h0F0, 2'd0, 4'b0011});
        base = iss_seen;
        send(7, 0, 'h0F0, 0, 2);
        send(7, 1, 'h0F0, 0, 4);
        wait_cyc(15);
        chk(iss_seen - base == 1, "R2 drained after first count", iss_seen - base, 1);
        exp_cpl.push_back({8'd7, 4'b0011}); respond('h0F0);
        wait_cyc(2);

        // R7 R1: full table stall, oldest-first drain
        send(8, 0, 'h100, 0, 2);
        send(9, 0, 'h200, 0, 2);
        in_seq = 8'd10; #1;
        chk(in_stall == 1, "R7 stall when full and new seq", in_stall, 1);
        in_seq = 8'd8; #1;
        chk(in_stall == 0, "R7 no stall for resident seq", in_stall, 0);
        base = iss_seen;
        send(9, 1, 'h200, 0, 2);
        wait_cyc(10);
        chk(iss_seen == base, "R1 younger waits for older", iss_seen - base, 0);
        exp_iss.push_back({12'h100, 2'd0, 4'b0011});
        exp_iss.push_back({12'h200, 2'd0, 4'b0011});
        send(8, 1, 'h100, 0, 2);
        wait_cyc(20);
        chk(iss_seen - base == 2, "R1 both drained", iss_seen - base, 2);
        exp_cpl.push_back({8'd8, 4'b0011}); respond('h100);
        exp_cpl.push_back({8'd9, 4'b0011}); respond('h200);
        wait_cyc(2);
        chk(dl_err == 0, "R8 no timeout on normal traffic", dl_err, 0);

        // R8: incomplete instruction trips the timeout
        send(10, 0, 'h300, 0, 2);
        wait_cyc(DL_THRESH - 10);
        chk(dl_err == 0, "R8 before threshold", dl_err, 0);
        wait_cyc(20);
        chk(dl_err == 1, "R8 after threshold", dl_err, 1);
        wait_cyc(5);
        chk(dl_err == 1, "R8 sticky", dl_err, 1);

        chk(exp_iss.size() == 0, "R5 all issues seen", exp_iss.size(), 0);
        chk(exp_cpl.size() == 0, "R6 all completions seen", exp_cpl.size(), 0);
        finish_run();
    end
endmodule